// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block turns digitised supply-comparator results and a manual-reset pin into a system reset. It drives an active-high and an active-low reset, an early low-line warning and a secondary-supply fail flag. The reset is held while the primary supply is below its trip level. Once the supply recovers, the reset is kept for a power-up hold-off that a two-bit code selects. When the supply falls, the low-line warning is raised first. The reset then follows a fixed gap later, so software has time to park before it loses the machine.

The manual-reset input is active low. Short glitches on it are filtered out. A real press forces reset quickly. After the pin is released, the reset goes back through the normal hold-off. The secondary-supply flag only reports the second comparator and never touches reset. Every delay is a count of ticks of the free-running clock. The counts come from two parameters: ticks per millisecond and nanoseconds per tick.

Top module: `supmon_rst_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with the primary flag low, `rst_o`=1, `rst_n_o`=0, `warn_o`=1 and `aux_fail_o`=0.
- R2: `rst_n_o` is always the exact complement of `rst_o`.
- R3: After `pri_ok_i` rises (with the manual reset idle), `rst_o` falls exactly HOLD+SYNC_STAGES+1 cycles later. HOLD = TICKS_PER_MS x {50, 200, 400, 800} for `pu_sel_i` = 00, 01, 10, 11.
- R4: If `pri_ok_i` falls during the hold-off, `rst_o` stays high, and the full hold-off is counted again from the next rise.
- R5: On power-down, `warn_o` rises SYNC_STAGES+1 cycles after `pri_ok_i` falls. `rst_o` then rises exactly LEAD cycles after `warn_o`, where LEAD = ceil(500 / NS_PER_TICK).
- R6: A primary dip that ends before the lead runs out pulses `warn_o` but never raises `rst_o`.
- R7: A low pulse on `mr_n_i` lasting fewer than GLITCH = ceil(50 / NS_PER_TICK) cycles has no effect on `rst_o`.
- R8: A low level on `mr_n_i` held for at least GLITCH cycles raises `rst_o` exactly SYNC_STAGES+1+GLITCH cycles after the fall, which is no more than LEAD.
- R9: After `mr_n_i` returns high, `rst_o` falls exactly HOLD+SYNC_STAGES+2 cycles later.
- R10: `aux_fail_o` rises SYNC_STAGES+1 cycles after `aux_ok_i` falls and clears the same way. It never changes `rst_o` or `warn_o`.
- R11: On power-up, `warn_o` falls SYNC_STAGES+1 cycles after `pri_ok_i` rises, while `rst_o` is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running tick clock |
| rst_n | input | 1 | Block reset, active low |
| pri_ok_i | input | 1 | Primary supply above trip (asynchronous) |
| aux_ok_i | input | 1 | Secondary supply above trip (asynchronous) |
| mr_n_i | input | 1 | Manual reset, active low (asynchronous) |
| pu_sel_i | input | 2 | Power-up hold-off select (quasi-static) |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |
| warn_o | output | 1 | Low-line early warning |
| aux_fail_o | output | 1 | Secondary supply below trip |

## Verification
The bench builds the block with TICKS_PER_MS=4 and NS_PER_TICK=8. This gives hold-offs of 200, 800, 1600 and 3200 cycles, a lead of 63 cycles and a glitch limit of 7 cycles. With these values all four hold-off codes can be measured to the exact cycle in one short run. Manual pulses one cycle either side of the glitch limit can be placed exactly. A primary dip shorter than the lead can be timed on purpose.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_DELAY = 2'd1,
      ST_RUN   = 2'd2,
      ST_LEAD  = 2'd3
   } seq_state_t;

   // hold-off length in milliseconds for each select code
   function automatic int unsigned holdoff_ms(input int unsigned code);
      case (code)
         0:       return 50;
         1:       return 200;
         2:       return 400;
         default: return 800;
      endcase
   endfunction

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= INIT;
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= INIT;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/supmon_mr_filter.sv
module supmon_mr_filter #(
   parameter int unsigned GLITCH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mr_n_s,
   output logic mr_act
);
   generate
      if (GLITCH <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mr_act <= 1'b0;
            else        mr_act <= ~mr_n_s;
         end
      end else begin : g_count
         localparam int unsigned GW = $clog2(GLITCH);
         localparam logic [GW-1:0] LAST = GW'(GLITCH - 1);
         logic [GW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt <= '0;
               mr_act  <= 1'b0;
            end else if (mr_n_s) begin
               low_cnt <= '0;
               mr_act  <= 1'b0;
            end else begin
               if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
               mr_act <= (low_cnt == LAST);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/supmon_seq_fsm.sv
module supmon_seq_fsm
   import supmon_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pri_ok,
   input  logic          mr_act,
   input  logic [CW-1:0] hold_len,
   input  logic [CW-1:0] lead_len,
   output logic          rst_hold
);
   seq_state_t    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HOLD;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_HOLD: begin
               if (pri_ok && !mr_act) begin
                  state <= ST_DELAY;
                  cnt   <= '0;
               end
            end
            ST_DELAY: begin
               if (!pri_ok || mr_act)           state <= ST_HOLD;
               else if (cnt == hold_len - 1'b1) state <= ST_RUN;
               else                             cnt   <= cnt + 1'b1;
            end
            ST_RUN: begin
               if (mr_act) state <= ST_HOLD;
               else if (!pri_ok) begin
                  state <= ST_LEAD;
                  cnt   <= '0;
               end
            end
            ST_LEAD: begin
               if (mr_act)                      state <= ST_HOLD;
               else if (pri_ok)                 state <= ST_RUN;
               else if (cnt == lead_len - 1'b1) state <= ST_HOLD;
               else                             cnt   <= cnt + 1'b1;
            end
            default: state <= ST_HOLD;
         endcase
      end
   end

   assign rst_hold = (state == ST_HOLD) || (state == ST_DELAY);
endmodule

// File: rtl/supmon_rst_seq.sv
module supmon_rst_seq
   import supmon_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS = 100000,
   parameter int unsigned NS_PER_TICK  = 10,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pri_ok_i,
   input  logic       aux_ok_i,
   input  logic       mr_n_i,
   input  logic [1:0] pu_sel_i,
   output logic       rst_o,
   output logic       rst_n_o,
   output logic       warn_o,
   output logic       aux_fail_o
);
   localparam int unsigned MAX_HOLD = holdoff_ms(3) * TICKS_PER_MS;
   localparam int unsigned LEAD     = ceil_div(500, NS_PER_TICK);
   localparam int unsigned GLITCH   = ceil_div(50, NS_PER_TICK);
   localparam int unsigned CW       = $clog2(MAX_HOLD + 1);

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (TICKS_PER_MS == 0 || NS_PER_TICK == 0) $error("tick parameters must be non-zero");
      if (LEAD >= MAX_HOLD) $error("lead must be shorter than the longest hold-off");
      if (SYNC_STAGES + 1 + GLITCH > LEAD) $error("manual reset cannot meet its activation bound");
   end

   logic [2:0]    sync_q;
   logic          pri_s, aux_s, mr_n_s;
   logic          mr_act;
   logic          rst_hold;
   logic          warn_q, aux_fail_q;
   logic [CW-1:0] hold_lut [4];
   logic [CW-1:0] hold_len;

   supmon_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .INIT   (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({mr_n_i, aux_ok_i, pri_ok_i}),
      .q_o   (sync_q)
   );
   assign pri_s  = sync_q[0];
   assign aux_s  = sync_q[1];
   assign mr_n_s = sync_q[2];

   supmon_mr_filter #(
      .GLITCH (GLITCH)
   ) u_mrf (
      .clk    (clk),
      .rst_n  (rst_n),
      .mr_n_s (mr_n_s),
      .mr_act (mr_act)
   );

   generate
      for (genvar k = 0; k < 4; k++) begin : g_lut
         assign hold_lut[k] = CW'(holdoff_ms(k) * TICKS_PER_MS);
      end
   endgenerate
   assign hold_len = hold_lut[pu_sel_i];

   supmon_seq_fsm #(
      .CW (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pri_ok   (pri_s),
      .mr_act   (mr_act),
      .hold_len (hold_len),
      .lead_len (CW'(LEAD)),
      .rst_hold (rst_hold)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_q     <= 1'b1;
         aux_fail_q <= 1'b0;
      end else begin
         warn_q     <= ~pri_s;
         aux_fail_q <= ~aux_s;
      end
   end

   assign rst_o      = rst_hold;
   assign rst_n_o    = ~rst_hold;
   assign warn_o     = warn_q;
   assign aux_fail_o = aux_fail_q;
endmodule

// File: rtl/supmon_rst_seq_chk.sv
module supmon_rst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic rst_o,
   input logic rst_n_o,
   input logic warn_o,
   input logic mr_act
);
   // R2
   a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n_o == ~rst_o);

   // R5: a power-down reset is preceded by the warning
   a_r5_warn_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_o) && warn_o && !$past(mr_act)) |-> $past(warn_o));

   // R3: release only with the supply good and no manual request
   a_r3_release_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o) |-> (!warn_o && !$past(mr_act)));

   // R4: reset is held while the supply is low
   a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_o && warn_o) |=> rst_o);

   // R8: a filtered manual request forces reset on the next edge
   a_r8_mr_forces: assert property (@(posedge clk) disable iff (!rst_n)
      mr_act |=> rst_o);
endmodule

bind supmon_rst_seq supmon_rst_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rst_o   (rst_o),
   .rst_n_o (rst_n_o),
   .warn_o  (warn_o),
   .mr_act  (mr_act)
);

// File: tb/supmon_rst_seq_test.sv
module supmon_rst_seq_test;
   localparam int TPM    = 4;
   localparam int NSPT   = 8;
   localparam int SYNC   = 2;
   localparam int LEAD   = (500 + NSPT - 1) / NSPT;
   localparam int GLITCH = (50 + NSPT - 1) / NSPT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pri_ok_i = 1'b0, aux_ok_i = 1'b1, mr_n_i = 1'b1;
   logic [1:0] pu_sel_i = 2'b01;
   logic rst_o, rst_n_o, warn_o, aux_fail_o;

   int total = 0, bad = 0, comp_bad = 0;

   always #4 clk = ~clk;

   supmon_rst_seq #(.TICKS_PER_MS(TPM), .NS_PER_TICK(NSPT), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .pri_ok_i(pri_ok_i), .aux_ok_i(aux_ok_i),
      .mr_n_i(mr_n_i), .pu_sel_i(pu_sel_i), .rst_o(rst_o), .rst_n_o(rst_n_o),
      .warn_o(warn_o), .aux_fail_o(aux_fail_o));

   function automatic int hold_of(input int code);
      case (code)
         0: return 50 * TPM;
         1: return 200 * TPM;
         2: return 400 * TPM;
         default: return 800 * TPM;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int which);
      case (which)
         0: return rst_o;
         1: return warn_o;
         default: return aux_fail_o;
      endcase
   endfunction

   // counts negedges until the chosen output equals val
   task automatic wait_for(input int which, input logic val, input int lim, output int n);
      n = 0;
      while (sig(which) !== val && n < lim) begin
         @(negedge clk);
         n++;
         if (rst_n_o !== ~rst_o) comp_bad++;
      end
   endtask

   // idle for n cycles, return how many cycles the output left val
   task automatic hold_check(input int which, input logic val, input int cyc, output int miss);
      miss = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (sig(which) !== val) miss++;
         if (rst_n_o !== ~rst_o) comp_bad++;
      end
   endtask

   task automatic t_reset();
      chk("R1 rst_o in reset", int'(rst_o), 1);
      chk("R1 rst_n_o in reset", int'(rst_n_o), 0);
      chk("R1 warn_o in reset", int'(warn_o), 1);
      chk("R1 aux_fail_o in reset", int'(aux_fail_o), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 rst_o held after reset, supply low", int'(rst_o), 1);
      chk("R1 warn_o after reset, supply low", int'(warn_o), 1);
   endtask

   task automatic t_powerup(input int code);
      int n1, n2;
      pu_sel_i = 2'(code);
      pri_ok_i = 1'b1;
      wait_for(1, 1'b0, 100, n1);
      chk("R11 warn fall latency", n1, SYNC + 1);
      chk("R11 reset still held at warn fall", int'(rst_o), 1);
      wait_for(0, 1'b0, 5000, n2);
      chk($sformatf("R3 hold-off code %0d", code), n1 + n2, hold_of(code) + SYNC + 1);
   endtask

   task automatic t_powerdown();
      int n1, n2;
      pri_ok_i = 1'b0;
      wait_for(1, 1'b1, 100, n1);
      chk("R5 warn rise latency", n1, SYNC + 1);
      chk("R5 reset low at warn rise", int'(rst_o), 0);
      wait_for(0, 1'b1, 500, n2);
      chk("R5 warn-to-reset gap", n2, LEAD);
   endtask

   task automatic t_dip();
      int n, miss;
      pri_ok_i = 1'b0;
      repeat (20) @(negedge clk);
      pri_ok_i = 1'b1;
      chk("R6 warn during dip", int'(warn_o), 1);
      hold_check(0, 1'b0, 2 * LEAD, miss);
      chk("R6 no reset on short dip", miss, 0);
      wait_for(1, 1'b0, 10, n);
      chk("R6 warn cleared after dip", int'(warn_o), 0);
   endtask

   task automatic t_restart();
      int n, miss;
      pri_ok_i = 1'b1;
      hold_check(0, 1'b1, 100, miss);
      pri_ok_i = 1'b0;
      hold_check(0, 1'b1, 5, n);
      pri_ok_i = 1'b1;
      chk("R4 reset held across dip", miss + n, 0);
      wait_for(0, 1'b0, 5000, n);
      chk("R4 hold-off restarted", n, hold_of(int'(pu_sel_i)) + SYNC + 1);
   endtask

   task automatic t_mr_glitch();
      int miss;
      mr_n_i = 1'b0;
      repeat (GLITCH - 1) @(negedge clk);
      mr_n_i = 1'b1;
      hold_check(0, 1'b0, 40, miss);
      chk("R7 short manual pulse ignored", miss, 0);
   endtask

   task automatic t_mr();
      int n;
      mr_n_i = 1'b0;
      wait_for(0, 1'b1, 100, n);
      chk("R8 manual activation latency", n, SYNC + 1 + GLITCH);
      chk("R8 within lead bound", int'(n <= LEAD), 1);
      repeat (30) @(negedge clk);
      mr_n_i = 1'b1;
      wait_for(0, 1'b0, 5000, n);
      chk("R9 release after manual", n, hold_of(int'(pu_sel_i)) + SYNC + 2);
   endtask

   task automatic t_aux();
      int n;
      aux_ok_i = 1'b0;
      wait_for(2, 1'b1, 50, n);
      chk("R10 aux fail latency", n, SYNC + 1);
      repeat (10) @(negedge clk);
      chk("R10 reset unaffected", int'(rst_o), 0);
      chk("R10 warn unaffected", int'(warn_o), 0);
      aux_ok_i = 1'b1;
      wait_for(2, 1'b0, 50, n);
      chk("R10 aux fail clear latency", n, SYNC + 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      for (int c = 0; c < 4; c++) begin
         t_powerup(c);
         t_powerdown();
      end
      pu_sel_i = 2'b00;
      t_restart();
      t_dip();
      t_mr_glitch();
      t_mr();
      t_aux();
      chk("R2 complement on every sampled cycle", comp_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule